// File: doc/BRIEF.md
# Ready/Status Pin Driver with Completion Pulse Modes

This block drives a single active-low ready/status pin for a program/erase engine. A stored 2-bit mode picks how the pin behaves. In level mode the pin is low for as long as the engine reports busy. In the three pulse modes the pin stays high and gives one fixed-length low pulse each time a qualifying operation finishes. The qualifying operations are erase only, program only, or either one.

The mode arrives on a configuration command stream. The low two bits of the command word hold the mode code, and the upper bits are reserved and must be zero. A command with any reserved bit set is rejected. The stored mode is then left unchanged, and both bits of a two-bit fault output are raised. The pulse length is given in nanoseconds and converted to a whole number of clock cycles, rounded up.

Top module: `sts_pin_driver`

## Requirements
- R1: After reset the mode is level (code 00), `fault_o` is 00, and `sts_o` equals the inverse of `eng_busy`.
- R2: In level mode (code 00), `sts_o` is `!eng_busy`, and the `prog_done` and `erase_done` strobes have no effect on it.
- R3: With code 01, a cycle with `erase_done` high starts a low pulse on `sts_o`. `prog_done` and `eng_busy` are ignored.
- R4: With code 10, a cycle with `prog_done` high starts a low pulse. `erase_done` and `eng_busy` are ignored.
- R5: With code 11, a cycle with either strobe high starts a low pulse.
- R6: A pulse holds `sts_o` low for exactly PULSE_CYC clock cycles, starting from the edge that samples the strobe. PULSE_CYC is ceil(PULSE_NS / CLK_PERIOD_NS), which is 13 with the defaults.
- R7: A qualifying strobe that arrives while a pulse is active restarts the full PULSE_CYC count.
- R8: `cfg_ready` is always high, so there is no back-pressure. A beat with `cfg_valid` high and `cfg_data[7:2]` all zero loads `cfg_data[1:0]` as the mode. The new mode applies from the next clock, and a strobe in the same cycle as the write is judged by the old mode.
- R9: A beat with `cfg_valid` high and any of `cfg_data[7:2]` set leaves the mode unchanged and sets both `fault_o` bits. The fault bits stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_busy | input | 1 | Engine busy level |
| prog_done | input | 1 | One-cycle strobe: program operation finished |
| erase_done | input | 1 | One-cycle strobe: erase operation finished |
| cfg_valid | input | 1 | Configuration beat valid |
| cfg_ready | output | 1 | Configuration beat accepted (always high) |
| cfg_data | input | CMD_W | Configuration word: [1:0] mode code, upper bits reserved |
| sts_o | output | 1 | Ready/status pin level (low = busy or pulse) |
| fault_o | output | 2 | Invalid configuration flags, both set together |

## Verification
The bench measures the exact number of low cycles after each strobe type in each mode. It catches a design that lets an ignored strobe fire, or that follows busy in a pulse mode, or that produces a pulse one cycle too short or too long. It fires a second strobe in the middle of a pulse. A design that drops or merges that event would end the pulse early. It sends a mode write and a strobe in the same cycle, which catches a design that applies the mode one cycle too early. It also sends a word with reserved bits set. A design that loaded that word anyway, or raised only one fault bit, or cleared the faults on a later valid write, would be reported.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    STS_LEVEL = 2'b00,
    STS_ERASE = 2'b01,
    STS_PROG  = 2'b10,
    STS_BOTH  = 2'b11
  } sts_mode_e;
endpackage

// File: rtl/sts_cfg_reg.sv
module sts_cfg_reg
  import sts_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_data,
  output sts_mode_e        mode_o,
  output logic [1:0]       fault_o
);
  localparam int RSV_LO = 2;

  logic bad_cmd;
  logic good_cmd;

  assign bad_cmd  = cmd_valid && (|cmd_data[CMD_W-1:RSV_LO]);
  assign good_cmd = cmd_valid && !(|cmd_data[CMD_W-1:RSV_LO]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_o <= STS_LEVEL;
    else if (good_cmd) mode_o <= sts_mode_e'(cmd_data[1:0]);
  end

  // two sticky fault flags, each its own register
  for (genvar g = 0; g < 2; g++) begin : g_fault
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fault_o[g] <= 1'b0;
      else if (bad_cmd) fault_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/sts_event_qual.sv
module sts_event_qual
  import sts_pkg::*;
(
  input  sts_mode_e mode_i,
  input  logic      prog_done,
  input  logic      erase_done,
  output logic      trig_o
);
  always_comb begin
    unique case (mode_i)
      STS_ERASE: trig_o = erase_done;
      STS_PROG:  trig_o = prog_done;
      STS_BOTH:  trig_o = erase_done | prog_done;
      default:   trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int PULSE_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (trig_i)           cnt_q <= CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/sts_pin_driver.sv
module sts_pin_driver
  import sts_pkg::*;
#(
  parameter int CMD_W         = 8,
  parameter int PULSE_NS      = 250,
  parameter int CLK_PERIOD_NS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_busy,
  input  logic             prog_done,
  input  logic             erase_done,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CMD_W-1:0] cfg_data,
  output logic             sts_o,
  output logic [1:0]       fault_o
);
  localparam int PULSE_CYC = (PULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  sts_mode_e mode_q;
  logic      trig;
  logic      pulse_on;

  assign cfg_ready = 1'b1;

  sts_cfg_reg #(.CMD_W(CMD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cfg_valid), .cmd_data(cfg_data),
    .mode_o(mode_q), .fault_o(fault_o)
  );

  sts_event_qual u_qual (
    .mode_i(mode_q), .prog_done(prog_done), .erase_done(erase_done), .trig_o(trig)
  );

  sts_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .active_o(pulse_on)
  );

  assign sts_o = (mode_q == STS_LEVEL) ? !eng_busy : !pulse_on;
endmodule

// File: rtl/sts_pin_driver_chk.sv
module sts_pin_driver_chk #(
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_busy,
  input logic             prog_done,
  input logic             erase_done,
  input logic             cfg_valid,
  input logic [CMD_W-1:0] cfg_data,
  input logic             sts_o,
  input logic [1:0]       fault_o,
  input logic [1:0]       mode_q
);
  logic bad_w;
  assign bad_w = cfg_valid && (|cfg_data[CMD_W-1:2]);

  a_r9_invalid_sets_faults: assert property (@(posedge clk) disable iff (!rst_n)
    bad_w |=> fault_o == 2'b11);

  a_r9_faults_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o[0] |=> fault_o[0]);

  a_r8_invalid_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    bad_w |=> $stable(mode_q));

  a_r8_valid_loads_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !bad_w) |=> mode_q == $past(cfg_data[1:0]));

  a_r3_erase_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && erase_done && !cfg_valid) |=> !sts_o);

  a_r4_prog_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && prog_done && !cfg_valid) |=> !sts_o);

  a_r2_level_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> (sts_o == !eng_busy));
endmodule

bind sts_pin_driver sts_pin_driver_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .prog_done(prog_done),
  .erase_done(erase_done), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
  .sts_o(sts_o), .fault_o(fault_o), .mode_q(mode_q)
);

// File: tb/test_sts_pin_driver.sv
module test_sts_pin_driver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eng_busy = 1'b0;
  logic       prog_done = 1'b0;
  logic       erase_done = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       cfg_ready;
  logic       sts_o;
  logic [1:0] fault_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam int WIN = 20;
  localparam int NVEC = 8;
  // {code[1:0], strobe[1:0] (bit0 prog, bit1 erase), busy, expected low count[4:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'b00, 2'b11, 1'b0, 5'd0},
    {2'b00, 2'b00, 1'b1, 5'd20},
    {2'b01, 2'b10, 1'b1, 5'd13},
    {2'b01, 2'b01, 1'b1, 5'd0},
    {2'b10, 2'b01, 1'b0, 5'd13},
    {2'b10, 2'b10, 1'b1, 5'd0},
    {2'b11, 2'b01, 1'b1, 5'd13},
    {2'b11, 2'b10, 1'b0, 5'd13}
  };

  always #10 clk = ~clk;

  sts_pin_driver i_sts_pin_driver (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .prog_done(prog_done),
    .erase_done(erase_done), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .sts_o(sts_o), .fault_o(fault_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_data = 8'h00;
    #1;
  endtask

  task automatic fire(input logic [1:0] kind);
    prog_done = kind[0]; erase_done = kind[1];
    @(negedge clk);
    prog_done = 1'b0; erase_done = 1'b0;
    #1;
  endtask

  task automatic count_low(output int n);
    n = 0;
    for (int i = 0; i < WIN; i++) begin
      if (i != 0) begin
        @(negedge clk);
        #1;
      end
      if (!sts_o) n++;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 sts", sts_o, 1);
    check("R1 fault", fault_o, 0);
    check("R8 ready", cfg_ready, 1);
    eng_busy = 1'b1; #1;
    check("R1 busy low", sts_o, 0);
    eng_busy = 1'b0; #1;

    // vector walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      write_cfg({6'b0, VEC[v][9:8]});
      eng_busy = VEC[v][5];
      fire(VEC[v][7:6]);
      count_low(n);
      check($sformatf("R2/R3/R4/R5/R6 vec%0d", v), n, int'(VEC[v][4:0]));
      eng_busy = 1'b0;
      repeat (2) @(negedge clk);
      #1;
    end

    // R7 restart in mid-pulse
    write_cfg(8'h03);
    fire(2'b01);
    repeat (5) @(negedge clk);
    #1;
    check("R7 still low", sts_o, 0);
    fire(2'b10);
    count_low(n);
    check("R7 restart", n, 13);

    // R8 new mode applies next clock only
    write_cfg(8'h00);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_data = 8'h01; erase_done = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_data = 8'h00; erase_done = 1'b0;
    #1;
    check("R8 same-cycle strobe uses old mode", sts_o, 1);
    fire(2'b10);
    check("R8 new mode active", sts_o, 0);
    repeat (15) @(negedge clk);
    #1;

    // R9 invalid word: mode kept (01), faults set
    write_cfg(8'h06);
    check("R9 faults set", fault_o, 3);
    fire(2'b01);
    check("R9 mode unchanged (prog ignored)", sts_o, 1);
    fire(2'b10);
    count_low(n);
    check("R9 mode unchanged (erase pulses)", n, 13);
    write_cfg(8'h00);
    check("R9 sticky", fault_o, 3);
    eng_busy = 1'b1; #1;
    check("R8 valid write after fault", sts_o, 0);
    eng_busy = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule